// File: doc/BRIEF.md
# NAND Flash Bus Cycle Sequencer

This block turns register writes from a simple memory-mapped bus into timed bus cycles on the pins of a raw 8-bit NAND flash device. Software first programs a timing register, which sets the length of three phases in controller clocks: setup, strobe and hold. It then writes a command byte, address bytes and data. Each flash-side access becomes one or more byte cycles. Command accesses raise the command latch, address accesses raise the address latch, and data accesses run plain cycles. A data read drops the read strobe instead of the write strobe and captures the flash bus at the end of the strobe phase.

A data access can carry one byte or a full 32-bit word. A word expands into four byte cycles, starting with the least significant byte. A control register enables the sequencer, drives the active-low chip enable and fires a one-clock clear pulse for an external ECC accumulator. A status register reports the synchronised ready/busy pin. While byte cycles are running, every bus access is held off through a ready/wait handshake until the last hold clock has finished.

Top module: `nand_seq_top`

## Requirements
- R1: After reset the flash pins are idle: chip enable high, both strobes high, both latches low, data bus not driven, ECC clear low. The timing register reads 0x7770 and the control register reads 0x2.
- R2: The timing register (byte offset 0x0) holds the setup count at bits 14:12, the strobe count at bits 10:8 and the hold count at bits 6:4, each stored as clocks minus one. A field value n makes its phase last n+1 clocks, and a one-byte write cycle drives the data bus for exactly the sum of the three phases.
- R3: A write to the command register (offset 0x8) produces one write cycle with the command latch high, the address latch low and bits 7:0 of the written word on the data bus.
- R4: A write to the address register (offset 0xC) produces one write cycle with the address latch high and the command latch low.
- R5: A 32-bit write to the data register (offset 0x10, word flag 1) produces four write cycles with both latches low, carrying bits 7:0, 15:8, 23:16 and 31:24 in that order.
- R6: A byte write to the data register (word flag 0) produces exactly one write cycle carrying bits 7:0.
- R7: A read of the data register keeps the read strobe low for the strobe count and samples the flash bus on the last strobe clock. A word read returns four bytes, the first in bits 7:0. A byte read returns one byte in bits 7:0 with zeros above it.
- R8: Status register bit 0 (offset 0x14) reads the ready/busy pin after a two-clock synchroniser: 1 means ready, 0 means busy.
- R9: Control register bit 0 enables the sequencer and bit 1 drives the chip enable pin directly. While bit 0 is 0, flash register accesses complete without any cycle, both strobes stay high, and data reads return zero.
- R10: Writing control bit 4 as 1 gives exactly one clock of ECC clear. The bit always reads back as 0.
- R11: While byte cycles run, every bus access waits with ready low. An access presented on the clock after a flash write is accepted waits exactly as many clocks as the cycles of that write take.
- R12: The two strobes are never low together, and the two latches are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_req | input | 1 | Register access request, held until bus_rdy |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_word | input | 1 | Data register width: 1 = 32-bit, 0 = byte |
| bus_addr | input | 5 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while bus_rdy is high |
| bus_rdy | output | 1 | Access completes on this clock |
| nand_nce | output | 1 | Flash chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_nwe | output | 1 | Write strobe, active low |
| nand_nre | output | 1 | Read strobe, active low |
| nand_dq_o | output | 8 | Flash data bus out |
| nand_dq_oe | output | 1 | Flash data bus drive enable |
| nand_dq_i | input | 8 | Flash data bus in |
| nand_rb | input | 1 | Flash ready/busy, 1 = ready |
| ecc_clr | output | 1 | One-clock clear for the external ECC accumulator |

## Verification
The timing is measured at the pins under three settings: the slowest reset value, an asymmetric 2/3/4 split and the minimum 1/1/1. The asymmetric split exposes a swapped field or an off-by-one phase count that a symmetric setting would hide. Command, address, byte-data and word-data writes use distinct byte values, so latch selection and lane order can be told apart. Reads use a flash model whose bus value changes with every strobe, so a wrong sampling clock or a wrong lane placement returns a different word. Each stall is counted in clocks against the programmed phase total.

// File: rtl/nand_seq_pkg.sv
// Package: shared types and register indices for the NAND cycle sequencer.
// Assumes registers sit on 32-bit aligned byte addresses.
package nand_seq_pkg;
    localparam int unsigned TIME_W = 3;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_SETUP,
        PH_PULSE,
        PH_HOLD
    } phase_e;

    typedef enum logic [1:0] {
        LAT_NONE,
        LAT_CMD,
        LAT_ADDR
    } latch_e;

    localparam int unsigned REG_CFG = 0;
    localparam int unsigned REG_CTL = 1;
    localparam int unsigned REG_CMD = 2;
    localparam int unsigned REG_ADR = 3;
    localparam int unsigned REG_DAT = 4;
    localparam int unsigned REG_STA = 5;
endpackage

// File: rtl/nand_ctrl_regs.sv
// Module: timing/control registers, ECC clear pulse and ready/busy synchroniser.
// Assumes the caller only raises the write strobes while no flash cycle runs.
module nand_ctrl_regs
    import nand_seq_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_cfg_i,
    input  logic [TIME_W-1:0] cfg_setup_i,
    input  logic [TIME_W-1:0] cfg_pulse_i,
    input  logic [TIME_W-1:0] cfg_hold_i,
    input  logic              wr_ctl_i,
    input  logic              ctl_en_i,
    input  logic              ctl_nce_i,
    input  logic              ctl_ecc_i,
    input  logic              rb_i,
    output logic [TIME_W-1:0] t_setup_o,
    output logic [TIME_W-1:0] t_pulse_o,
    output logic [TIME_W-1:0] t_hold_o,
    output logic              en_o,
    output logic              nce_o,
    output logic              ecc_clr_o,
    output logic              ready_o
);
    logic [SYNC_STAGES-1:0] rb_sync;

    // Timing fields: reset to the slowest setting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            t_setup_o <= '1;
            t_pulse_o <= '1;
            t_hold_o  <= '1;
        end else if (wr_cfg_i) begin
            t_setup_o <= cfg_setup_i;
            t_pulse_o <= cfg_pulse_i;
            t_hold_o  <= cfg_hold_i;
        end
    end

    // Control bits: enable, chip enable level, and self-clearing ECC clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_o      <= 1'b0;
            nce_o     <= 1'b1;
            ecc_clr_o <= 1'b0;
        end else begin
            ecc_clr_o <= wr_ctl_i && ctl_ecc_i;
            if (wr_ctl_i) begin
                en_o  <= ctl_en_i;
                nce_o <= ctl_nce_i;
            end
        end
    end

    // Ready/busy synchroniser chain.
    generate
        if (SYNC_STAGES > 1) begin : g_chain
            always_ff @(posedge clk) begin
                if (!rst_n) rb_sync <= '0;
                else        rb_sync <= {rb_sync[SYNC_STAGES-2:0], rb_i};
            end
        end else begin : g_single
            always_ff @(posedge clk) begin
                if (!rst_n) rb_sync <= '0;
                else        rb_sync <= rb_i;
            end
        end
    endgenerate

    assign ready_o = rb_sync[SYNC_STAGES-1];
endmodule

// File: rtl/nand_cycle_engine.sv
// Module: runs one or more byte cycles, each in setup, strobe and hold phases.
// Assumes timing inputs stay steady while busy_o is high; start_i is only
// honoured while idle. Read data is sampled on the last strobe clock.
module nand_cycle_engine
    import nand_seq_pkg::*;
#(
    parameter int unsigned FLASH_W = 8,
    parameter int unsigned LANES   = 4,
    localparam int unsigned IDX_W  = (LANES > 1) ? $clog2(LANES) : 1,
    localparam int unsigned WORD_W = FLASH_W * LANES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              write_i,
    input  latch_e            latch_i,
    input  logic [IDX_W-1:0]  last_idx_i,
    input  logic [WORD_W-1:0] wdata_i,
    input  logic [TIME_W-1:0] t_setup_i,
    input  logic [TIME_W-1:0] t_pulse_i,
    input  logic [TIME_W-1:0] t_hold_i,
    input  logic [FLASH_W-1:0] dq_in_i,
    output logic              busy_o,
    output logic              last_o,
    output logic              cle_o,
    output logic              ale_o,
    output logic              nwe_o,
    output logic              nre_o,
    output logic [FLASH_W-1:0] dq_out_o,
    output logic              dq_oe_o,
    output logic [WORD_W-1:0] rdata_o
);
    phase_e             phase;
    logic [TIME_W-1:0]  cnt;
    logic [IDX_W-1:0]   idx;
    logic [IDX_W-1:0]   last_idx;
    logic               wr_q;
    latch_e             lat_q;
    logic [WORD_W-1:0]  wbuf;
    logic [FLASH_W-1:0] lane_w [LANES];
    logic [TIME_W:0]    low_run;

    // Split the write buffer into byte lanes.
    genvar g;
    generate
        for (g = 0; g < LANES; g++) begin : g_lane
            assign lane_w[g] = wbuf[g*FLASH_W +: FLASH_W];
        end
    endgenerate

    // Phase sequencer: counts each phase down from its field value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase    <= PH_IDLE;
            cnt      <= '0;
            idx      <= '0;
            last_idx <= '0;
            wr_q     <= 1'b1;
            lat_q    <= LAT_NONE;
            wbuf     <= '0;
            rdata_o  <= '0;
        end else begin
            case (phase)
                PH_IDLE: if (start_i) begin
                    phase    <= PH_SETUP;
                    cnt      <= t_setup_i;
                    idx      <= '0;
                    last_idx <= last_idx_i;
                    wr_q     <= write_i;
                    lat_q    <= latch_i;
                    wbuf     <= wdata_i;
                    if (!write_i) rdata_o <= '0;
                end
                PH_SETUP: begin
                    if (cnt == '0) begin
                        phase <= PH_PULSE;
                        cnt   <= t_pulse_i;
                    end else cnt <= cnt - 1'b1;
                end
                PH_PULSE: begin
                    if (cnt == '0) begin
                        phase <= PH_HOLD;
                        cnt   <= t_hold_i;
                        if (!wr_q) rdata_o[idx*FLASH_W +: FLASH_W] <= dq_in_i;
                    end else cnt <= cnt - 1'b1;
                end
                default: begin
                    if (cnt == '0) begin
                        if (idx == last_idx) phase <= PH_IDLE;
                        else begin
                            idx   <= idx + 1'b1;
                            phase <= PH_SETUP;
                            cnt   <= t_setup_i;
                        end
                    end else cnt <= cnt - 1'b1;
                end
            endcase
        end
    end

    // Pin drive derived from the current phase.
    always_comb begin
        busy_o   = (phase != PH_IDLE);
        last_o   = (phase == PH_HOLD) && (cnt == '0) && (idx == last_idx);
        cle_o    = busy_o && (lat_q == LAT_CMD);
        ale_o    = busy_o && (lat_q == LAT_ADDR);
        nwe_o    = !((phase == PH_PULSE) && wr_q);
        nre_o    = !((phase == PH_PULSE) && !wr_q);
        dq_oe_o  = busy_o && wr_q;
        dq_out_o = lane_w[idx];
    end

    // Strobe run length, for the strobe-width check.
    always_ff @(posedge clk) begin
        if (!rst_n)                 low_run <= '0;
        else if (phase == PH_PULSE) low_run <= low_run + 1'b1;
        else                        low_run <= '0;
    end

    // R12
    nwe_nre_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!nwe_o && !nre_o));
    // R12
    cle_ale_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cle_o && ale_o));
    // R2
    pulse_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_PULSE && cnt == '0) |-> (low_run == {1'b0, t_pulse_i}));
    // R3
    dq_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!nwe_o && $past(!nwe_o)) |-> ($stable(dq_out_o) && $stable(cle_o) && $stable(ale_o)));
endmodule

// File: rtl/nand_seq_top.sv
// Module: bus decode and handshake for the NAND cycle sequencer.
// Assumes bus_req stays high with steady fields until bus_rdy is seen.
// Misaligned addresses read zero and are otherwise ignored.
module nand_seq_top
    import nand_seq_pkg::*;
#(
    parameter int unsigned ADDR_W  = 5,
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned FLASH_W = 8,
    localparam int unsigned LANES  = DATA_W / FLASH_W,
    localparam int unsigned IDX_W  = (LANES > 1) ? $clog2(LANES) : 1,
    localparam int unsigned REG_W  = ADDR_W - 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_req,
    input  logic               bus_we,
    input  logic               bus_word,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    output logic               bus_rdy,
    output logic               nand_nce,
    output logic               nand_cle,
    output logic               nand_ale,
    output logic               nand_nwe,
    output logic               nand_nre,
    output logic [FLASH_W-1:0] nand_dq_o,
    output logic               nand_dq_oe,
    input  logic [FLASH_W-1:0] nand_dq_i,
    input  logic               nand_rb,
    output logic               ecc_clr
);
    localparam logic [IDX_W-1:0] LAST_LANE = IDX_W'(LANES - 1);

    logic [REG_W-1:0]  reg_idx;
    logic              addr_ok, hit_cfg, hit_ctl, hit_cmd, hit_adr, hit_dat, hit_sta;
    logic              is_flash, dat_rd, eng_start, eng_busy, eng_last;
    logic              rd_active, rd_done;
    logic [TIME_W-1:0] t_setup, t_pulse, t_hold;
    logic              ctl_en, ready;
    latch_e            lat_sel;
    logic [DATA_W-1:0] eng_rdata, dat_word;

    // Register decode.
    always_comb begin
        reg_idx  = bus_addr[ADDR_W-1:2];
        addr_ok  = (bus_addr[1:0] == 2'b00);
        hit_cfg  = addr_ok && (reg_idx == REG_W'(REG_CFG));
        hit_ctl  = addr_ok && (reg_idx == REG_W'(REG_CTL));
        hit_cmd  = addr_ok && (reg_idx == REG_W'(REG_CMD));
        hit_adr  = addr_ok && (reg_idx == REG_W'(REG_ADR));
        hit_dat  = addr_ok && (reg_idx == REG_W'(REG_DAT));
        hit_sta  = addr_ok && (reg_idx == REG_W'(REG_STA));
        is_flash = hit_cmd || hit_adr || hit_dat;
        dat_rd   = bus_req && !bus_we && hit_dat;
        lat_sel  = hit_cmd ? LAT_CMD : (hit_adr ? LAT_ADDR : LAT_NONE);
    end

    // Handshake: stall all accesses while busy; data reads wait for their bytes.
    always_comb begin
        bus_rdy   = bus_req && !eng_busy && !(dat_rd && ctl_en && !rd_done);
        eng_start = bus_req && !eng_busy && ctl_en &&
                    ((bus_we && is_flash) || (dat_rd && !rd_done));
    end

    // Read completion tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_active <= 1'b0;
            rd_done   <= 1'b0;
        end else begin
            if (eng_start && !bus_we)        rd_active <= 1'b1;
            else if (eng_last)               rd_active <= 1'b0;
            if (bus_rdy)                     rd_done   <= 1'b0;
            else if (eng_last && rd_active)  rd_done   <= 1'b1;
        end
    end

    // Read data multiplexer.
    always_comb begin
        dat_word = bus_word ? eng_rdata : {{(DATA_W-FLASH_W){1'b0}}, eng_rdata[FLASH_W-1:0]};
        bus_rdata = '0;
        if (hit_cfg)      bus_rdata[14:4] = {t_setup, 1'b0, t_pulse, 1'b0, t_hold};
        else if (hit_ctl) bus_rdata[1:0]  = {nand_nce, ctl_en};
        else if (hit_sta) bus_rdata[0]    = ready;
        else if (hit_dat && ctl_en) bus_rdata = dat_word;
    end

    nand_ctrl_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_cfg_i   (bus_rdy && bus_we && hit_cfg),
        .cfg_setup_i(bus_wdata[14:12]),
        .cfg_pulse_i(bus_wdata[10:8]),
        .cfg_hold_i (bus_wdata[6:4]),
        .wr_ctl_i   (bus_rdy && bus_we && hit_ctl),
        .ctl_en_i   (bus_wdata[0]),
        .ctl_nce_i  (bus_wdata[1]),
        .ctl_ecc_i  (bus_wdata[4]),
        .rb_i       (nand_rb),
        .t_setup_o  (t_setup),
        .t_pulse_o  (t_pulse),
        .t_hold_o   (t_hold),
        .en_o       (ctl_en),
        .nce_o      (nand_nce),
        .ecc_clr_o  (ecc_clr),
        .ready_o    (ready)
    );

    nand_cycle_engine #(.FLASH_W(FLASH_W), .LANES(LANES)) u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (eng_start),
        .write_i   (bus_we),
        .latch_i   (lat_sel),
        .last_idx_i((hit_dat && bus_word) ? LAST_LANE : '0),
        .wdata_i   (bus_wdata),
        .t_setup_i (t_setup),
        .t_pulse_i (t_pulse),
        .t_hold_i  (t_hold),
        .dq_in_i   (nand_dq_i),
        .busy_o    (eng_busy),
        .last_o    (eng_last),
        .cle_o     (nand_cle),
        .ale_o     (nand_ale),
        .nwe_o     (nand_nwe),
        .nre_o     (nand_nre),
        .dq_out_o  (nand_dq_o),
        .dq_oe_o   (nand_dq_oe),
        .rdata_o   (eng_rdata)
    );

    // R11
    stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eng_busy |-> !bus_rdy);
    // R9
    idle_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_en |-> (nand_nwe && nand_nre));
    // R9
    nce_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_busy && $past(eng_busy)) |-> $stable(nand_nce));
endmodule

// File: tb/nand_seq_top_test.sv
module nand_seq_top_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_req = 1'b0, bus_we = 1'b0, bus_word = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_rdy;
    logic        nand_nce, nand_cle, nand_ale, nand_nwe, nand_nre, nand_dq_oe, ecc_clr;
    logic [7:0]  nand_dq_o, nand_dq_i;
    logic        nand_rb = 1'b1;

    int total = 0, bad = 0;
    bit finished = 1'b0;

    // Monitor state
    int low_w = 0, low_r = 0, oe_n = 0, ecc_n = 0, viol = 0, ev_n = 0, setup_run = 0, rd_ptr = 0;
    bit prev_nwe = 1'b1, prev_nre = 1'b1;
    logic [7:0] ev_dq [64];
    bit ev_cle [64];
    bit ev_ale [64];
    int ev_setup [64];

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [7:0] pat(input int p);
        return 8'hA5 ^ 8'(p * 29);
    endfunction

    assign nand_dq_i = pat(rd_ptr);

    nand_seq_top uut (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we), .bus_word(bus_word),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rdy(bus_rdy),
        .nand_nce(nand_nce), .nand_cle(nand_cle), .nand_ale(nand_ale), .nand_nwe(nand_nwe),
        .nand_nre(nand_nre), .nand_dq_o(nand_dq_o), .nand_dq_oe(nand_dq_oe),
        .nand_dq_i(nand_dq_i), .nand_rb(nand_rb), .ecc_clr(ecc_clr)
    );

    // Pin monitor sampled between edges
    always @(negedge clk) begin
        if (rst_n) begin
            if (!nand_nwe) low_w++;
            if (!nand_nre) low_r++;
            if (nand_dq_oe) oe_n++;
            if (ecc_clr) ecc_n++;
            if ((!nand_nwe && !nand_nre) || (nand_cle && nand_ale)) viol++;
            if (!nand_dq_oe) setup_run = 0;
            else if (nand_nwe) setup_run++;
            if (prev_nwe && !nand_nwe) begin
                ev_dq[ev_n % 64] = nand_dq_o;
                ev_cle[ev_n % 64] = nand_cle;
                ev_ale[ev_n % 64] = nand_ale;
                ev_setup[ev_n % 64] = setup_run;
                setup_run = 0;
                ev_n++;
            end
            if (!prev_nre && nand_nre) rd_ptr++;
            prev_nwe = nand_nwe;
            prev_nre = nand_nre;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic bus(input logic [4:0] a, input bit we, input bit wd, input logic [31:0] d,
                       output logic [31:0] rd, output int waits);
        @(negedge clk);
        bus_req = 1'b1; bus_we = we; bus_word = wd; bus_addr = a; bus_wdata = d;
        waits = 0; rd = '0;
        forever begin
            #1;
            if (bus_rdy) begin
                rd = bus_rdata;
                @(posedge clk);
                break;
            end
            waits++;
            if (waits > 2000) begin
                chk(1'b0, "R11 handshake timeout", 32'(waits), 0);
                break;
            end
            @(negedge clk);
        end
        #1 bus_req = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] r; int w;
        chk(nand_nce === 1'b1 && nand_nwe === 1'b1 && nand_nre === 1'b1, "R1 strobes/nce", {nand_nce, nand_nwe, nand_nre}, 3'b111);
        chk(nand_cle === 1'b0 && nand_ale === 1'b0 && nand_dq_oe === 1'b0 && ecc_clr === 1'b0, "R1 latches/oe", {nand_cle, nand_ale, nand_dq_oe, ecc_clr}, 0);
        bus(5'h00, 0, 1, 0, r, w); chk(r == 32'h7770, "R1 cfg reset", r, 32'h7770);
        bus(5'h04, 0, 1, 0, r, w); chk(r == 32'h2, "R1 ctl reset", r, 32'h2);
    endtask

    task automatic t_disabled();
        logic [31:0] r; int w; int e0 = ev_n; int l0 = low_w; int r0 = low_r;
        bus(5'h08, 1, 1, 32'h90, r, w);
        bus(5'h10, 0, 1, 0, r, w);
        chk(r == 0, "R9 disabled read zero", r, 0);
        repeat (30) @(negedge clk);
        chk(ev_n == e0 && low_w == l0 && low_r == r0, "R9 no cycle while disabled", 32'(low_w - l0 + low_r - r0), 0);
    endtask

    task automatic t_enable();
        logic [31:0] r; int w;
        bus(5'h04, 1, 1, 32'h1, r, w);
        @(negedge clk);
        chk(nand_nce == 1'b0, "R9 nce low", nand_nce, 0);
        bus(5'h04, 0, 1, 0, r, w); chk(r == 32'h1, "R9 ctl readback", r, 32'h1);
    endtask

    task automatic one_cmd(input int s, input int p, input int h, input string tag);
        logic [31:0] r; int w; int e0, o0, l0;
        bus(5'h00, 1, 1, (s << 12) | (p << 8) | (h << 4), r, w);
        e0 = ev_n; o0 = oe_n; l0 = low_w;
        bus(5'h08, 1, 1, 32'h0000_1270, r, w);
        bus(5'h14, 0, 1, 0, r, w);
        chk(w == s + p + h + 3, {tag, " R11 stall"}, 32'(w), 32'(s + p + h + 3));
        @(negedge clk);
        chk(oe_n - o0 == s + p + h + 3, {tag, " R2 total"}, 32'(oe_n - o0), 32'(s + p + h + 3));
        chk(low_w - l0 == p + 1, {tag, " R2 strobe"}, 32'(low_w - l0), 32'(p + 1));
        chk(ev_n - e0 == 1 && ev_setup[e0 % 64] == s + 1, {tag, " R2 setup"}, 32'(ev_setup[e0 % 64]), 32'(s + 1));
        chk(ev_cle[e0 % 64] && !ev_ale[e0 % 64] && ev_dq[e0 % 64] == 8'h70, {tag, " R3 cmd byte"}, {ev_cle[e0 % 64], ev_ale[e0 % 64], ev_dq[e0 % 64]}, {2'b10, 8'h70});
    endtask

    task automatic t_addr();
        logic [31:0] r; int w; int e0 = ev_n;
        bus(5'h0C, 1, 1, 32'h3C, r, w);
        bus(5'h14, 0, 1, 0, r, w);
        chk(ev_n - e0 == 1 && ev_ale[e0 % 64] && !ev_cle[e0 % 64] && ev_dq[e0 % 64] == 8'h3C, "R4 addr cycle",
            {ev_cle[e0 % 64], ev_ale[e0 % 64], ev_dq[e0 % 64]}, {2'b01, 8'h3C});
    endtask

    task automatic t_word_write();
        logic [31:0] r; int w; int e0 = ev_n; logic [31:0] got = 0; bit lat = 0;
        bus(5'h10, 1, 1, 32'hDDCC_BBAA, r, w);
        bus(5'h14, 0, 1, 0, r, w);
        chk(w == 4 * 9, "R11 word stall", 32'(w), 36);
        for (int k = 0; k < 4; k++) begin
            got[k*8 +: 8] = ev_dq[(e0 + k) % 64];
            lat = lat | ev_cle[(e0 + k) % 64] | ev_ale[(e0 + k) % 64];
        end
        chk(ev_n - e0 == 4 && got == 32'hDDCC_BBAA && !lat, "R5 word order", got, 32'hDDCC_BBAA);
    endtask

    task automatic t_byte_write();
        logic [31:0] r; int w; int e0 = ev_n;
        bus(5'h10, 1, 0, 32'h1122_335E, r, w);
        bus(5'h14, 0, 1, 0, r, w);
        chk(ev_n - e0 == 1 && ev_dq[e0 % 64] == 8'h5E, "R6 single byte", 32'(ev_n - e0), 1);
    endtask

    task automatic t_reads();
        logic [31:0] r, exp; int w; int p = rd_ptr; int l0 = low_r;
        bus(5'h10, 0, 1, 0, r, w);
        exp = {pat(p + 3), pat(p + 2), pat(p + 1), pat(p)};
        chk(r == exp, "R7 word read", r, exp);
        @(negedge clk);
        chk(low_r - l0 == 4 * 3, "R7 read strobe width", 32'(low_r - l0), 12);
        p = rd_ptr;
        bus(5'h10, 0, 0, 0, r, w);
        exp = {24'h0, pat(p)};
        chk(r == exp, "R7 byte read", r, exp);
    endtask

    task automatic t_status();
        logic [31:0] r; int w;
        @(negedge clk) nand_rb = 1'b0;
        repeat (3) @(negedge clk);
        bus(5'h14, 0, 1, 0, r, w); chk(r == 0, "R8 busy", r, 0);
        @(negedge clk) nand_rb = 1'b1;
        repeat (3) @(negedge clk);
        bus(5'h14, 0, 1, 0, r, w); chk(r == 1, "R8 ready", r, 1);
    endtask

    task automatic t_ecc_nce();
        logic [31:0] r; int w; int c0 = ecc_n;
        bus(5'h04, 1, 1, 32'h11, r, w);
        repeat (4) @(negedge clk);
        chk(ecc_n - c0 == 1, "R10 one clear pulse", 32'(ecc_n - c0), 1);
        bus(5'h04, 0, 1, 0, r, w); chk(r == 32'h1, "R10 bit self-clears", r, 1);
        bus(5'h04, 1, 1, 32'h3, r, w);
        @(negedge clk);
        chk(nand_nce == 1'b1, "R9 nce high", nand_nce, 1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_disabled();
        t_enable();
        one_cmd(7, 7, 7, "slow");
        one_cmd(1, 2, 3, "mixed");
        t_addr();
        t_word_write();
        t_byte_write();
        t_reads();
        one_cmd(0, 0, 0, "fast");
        t_status();
        t_ecc_nce();
        chk(viol == 0, "R12 exclusivity", 32'(viol), 0);
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog R11 actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule